// File: doc/BRIEF.md
# Flow-Slot Extension Compositor

This block is the second stage of an instruction decoder for a wide-issue machine. Each flow slot of an instruction may keep extra payload in two side blocks. One is a block of bytes. The other is a block of 4-bit morsels. Every slot carries a 2-bit byte-count code and a 2-bit morsel-count code. The block turns these codes into offsets within the side blocks. It then gathers each slot's payload into a fixed 44-bit lane of a 308-bit compositing buffer, and fills with zeros wherever a slot supplied nothing.

The count codes are read for all seven slot positions. The block does not know how many slots the instruction really uses, so trailing lanes may hold garbage that later stages ignore. From the composited buffer, the block picks out two fields. The first is a 128-bit literal that starts at a chosen lane and can be ones'-complemented to express a negative value. The second is a 64-bit argument list of sixteen 4-bit entries that starts at a chosen lane, together with a valid mask of contiguous bits.

The block is a two-stage valid/ready pipeline. The first stage computes the offsets and the second stage routes the data. Results appear two cycles after an instruction is accepted, and one instruction can be accepted per cycle.

Top module: `fc_compositor`

## Requirements
- R1: Byte-count code c of slot s (bits [2s+1:2s] of `byte_code_i`) means 0, 1, 2 or 4 bytes for c = 0, 1, 2, 3. Slot s reads its bytes from the byte block starting at byte offset equal to the sum of the byte counts of slots 0..s-1. Byte j of the slot goes to lane bits [8j+7:8j]. Unused bits in [31:0] are zero.
- R2: Morsel-count code m of slot s (bits [2s+1:2s] of `morsel_code_i`) means m morsels. Slot s reads its morsels from the morsel block starting at morsel offset equal to the sum of the morsel counts of slots 0..s-1. Morsel j goes to lane bits [32+4j+3:32+4j]. Unused bits in [43:32] are zero.
- R3: Lane s occupies bits [44s+43:44s] of `buf_o`.
- R4: `lit_o` is the 128 bits of the buffer starting at bit 44×`lit_slot_i`, with zeros above the buffer end. `lit_o` is bitwise inverted when `lit_neg_i` is 1.
- R5: `list_o` is the 64 bits of the buffer starting at bit 44×`list_slot_i`, with zeros above the buffer end. `list_mask_o` has bits [L-1:0] set, where L = `list_len_i`. Any length above 16 gives all 16 bits set.
- R6: An instruction accepted on an edge where `valid_i` and `ready_o` are both 1 appears with `valid_o` = 1 after the second following edge, provided `ready_i` stays 1.
- R7: While `valid_o` = 1 and `ready_i` = 0, `ready_o` is 0 and all outputs hold their values.
- R8: During and after reset, `valid_o` is 0 and `ready_o` is 1.
- R9: With `ready_i` held at 1, instructions accepted on consecutive cycles leave the block on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present at the input |
| ready_o | output | 1 | Block can accept an instruction |
| byte_code_i | input | 14 | Byte-count code per slot, 2 bits each |
| morsel_code_i | input | 14 | Morsel-count code per slot, 2 bits each |
| con_blk_i | input | 224 | Isolated byte block, byte 0 in the low bits |
| ext_blk_i | input | 84 | Isolated morsel block, morsel 0 in the low bits |
| lit_slot_i | input | 3 | First lane of the wide literal |
| lit_neg_i | input | 1 | Ones'-complement the literal |
| list_slot_i | input | 3 | First lane of the argument list |
| list_len_i | input | 5 | Argument list length |
| valid_o | output | 1 | Result present at the output |
| ready_i | input | 1 | Downstream can take the result |
| buf_o | output | 308 | Composited buffer, 7 lanes of 44 bits |
| lit_o | output | 128 | Selected and optionally inverted literal |
| list_o | output | 64 | Selected argument list |
| list_mask_o | output | 16 | Valid-entry mask of the list |

## Verification
The compositor is driven with count-code patterns that include all slots full, all slots empty, and several mixed patterns with different codes per slot. These patterns show whether the prefix offsets, the low-first order within a lane and the zero-fill are each correct. The literal and list selectors are tried at lanes deep enough that the field runs past the end of the buffer, with inversion on and off, and with list lengths of 0, 1, 16 and a value above 16. Back-to-back issue and a stall with a second instruction waiting show whether results keep their order and stay stable under backpressure.

// File: rtl/fc_pkg.sv
package fc_pkg;

  // byte-count code: 0,1,2 -> same value, 3 -> four bytes
  function automatic logic [2:0] byte_cnt(input logic [1:0] code);
    return (code == 2'd3) ? 3'd4 : {1'b0, code};
  endfunction

endpackage

// File: rtl/fc_offset_calc.sv
module fc_offset_calc #(
  parameter int NUM_SLOTS = 7,
  parameter int BOFF_W    = 5,
  parameter int MOFF_W    = 5
) (
  input  logic [NUM_SLOTS*2-1:0]      byte_code_i,
  input  logic [NUM_SLOTS*2-1:0]      morsel_code_i,
  output logic [NUM_SLOTS*BOFF_W-1:0] boff_o,
  output logic [NUM_SLOTS*MOFF_W-1:0] moff_o,
  output logic [NUM_SLOTS*3-1:0]      nbytes_o,
  output logic [NUM_SLOTS*2-1:0]      nmors_o
);

  // exclusive prefix sums over the slot counts
  always_comb begin
    int bacc;
    int macc;
    logic [2:0] bc;
    bacc = 0;
    macc = 0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      bc = fc_pkg::byte_cnt(byte_code_i[2*s +: 2]);
      nbytes_o[3*s +: 3]        = bc;
      nmors_o[2*s +: 2]         = morsel_code_i[2*s +: 2];
      boff_o[BOFF_W*s +: BOFF_W] = BOFF_W'(bacc);
      moff_o[MOFF_W*s +: MOFF_W] = MOFF_W'(macc);
      bacc = bacc + int'(bc);
      macc = macc + int'(morsel_code_i[2*s +: 2]);
    end
  end

endmodule

// File: rtl/fc_lane_router.sv
module fc_lane_router #(
  parameter int BYTES_PER_SLOT   = 4,
  parameter int MORSELS_PER_SLOT = 3,
  parameter int MORSEL_W         = 4,
  parameter int CON_W            = 224,
  parameter int EXT_W            = 84,
  parameter int BOFF_W           = 5,
  parameter int MOFF_W           = 5,
  parameter int LANE_W           = 44
) (
  input  logic [CON_W-1:0]  con_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic [BOFF_W-1:0] boff_i,
  input  logic [MOFF_W-1:0] moff_i,
  input  logic [2:0]        nbytes_i,
  input  logic [1:0]        nmors_i,
  output logic [LANE_W-1:0] lane_o
);

  localparam int BWIN_W = BYTES_PER_SLOT * 8;
  localparam int MWIN_W = MORSELS_PER_SLOT * MORSEL_W;

  logic [BWIN_W-1:0] bwin;
  logic [MWIN_W-1:0] mwin;

  assign bwin = BWIN_W'(con_i >> (int'(boff_i) * 8));
  assign mwin = MWIN_W'(ext_i >> (int'(moff_i) * MORSEL_W));

  always_comb begin
    lane_o = '0;
    for (int j = 0; j < BYTES_PER_SLOT; j++)
      if (j < int'(nbytes_i)) lane_o[8*j +: 8] = bwin[8*j +: 8];
    for (int j = 0; j < MORSELS_PER_SLOT; j++)
      if (j < int'(nmors_i)) lane_o[BWIN_W + MORSEL_W*j +: MORSEL_W] = mwin[MORSEL_W*j +: MORSEL_W];
  end

endmodule

// File: rtl/fc_field_select.sv
module fc_field_select #(
  parameter int BUF_W  = 308,
  parameter int LANE_W = 44,
  parameter int SLOT_W = 3,
  parameter int LIT_W  = 128,
  parameter int LIST_N = 16,
  parameter int LIST_W = 64,
  parameter int LEN_W  = 5
) (
  input  logic [BUF_W-1:0]  buf_i,
  input  logic [SLOT_W-1:0] lit_slot_i,
  input  logic              lit_neg_i,
  input  logic [SLOT_W-1:0] list_slot_i,
  input  logic [LEN_W-1:0]  list_len_i,
  output logic [LIT_W-1:0]  lit_o,
  output logic [LIST_W-1:0] list_o,
  output logic [LIST_N-1:0] mask_o
);

  localparam int PAD_W = BUF_W + LIT_W;

  logic [PAD_W-1:0] padded;
  logic [LIT_W-1:0] lit_raw;

  // zero extension above the buffer end supplies the fill for high lanes
  assign padded  = {{LIT_W{1'b0}}, buf_i};
  assign lit_raw = LIT_W'(padded >> (int'(lit_slot_i) * LANE_W));
  assign lit_o   = lit_neg_i ? ~lit_raw : lit_raw;
  assign list_o  = LIST_W'(padded >> (int'(list_slot_i) * LANE_W));

  always_comb
    for (int k = 0; k < LIST_N; k++) mask_o[k] = (k < int'(list_len_i));

endmodule

// File: rtl/fc_compositor.sv
module fc_compositor #(
  parameter int NUM_SLOTS        = 7,
  parameter int BYTES_PER_SLOT   = 4,
  parameter int MORSELS_PER_SLOT = 3,
  parameter int MORSEL_W         = 4,
  parameter int LIT_W            = 128,
  parameter int LIST_N           = 16
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         valid_i,
  output logic                                         ready_o,
  input  logic [NUM_SLOTS*2-1:0]                       byte_code_i,
  input  logic [NUM_SLOTS*2-1:0]                       morsel_code_i,
  input  logic [NUM_SLOTS*BYTES_PER_SLOT*8-1:0]        con_blk_i,
  input  logic [NUM_SLOTS*MORSELS_PER_SLOT*MORSEL_W-1:0] ext_blk_i,
  input  logic [$clog2(NUM_SLOTS+1)-1:0]               lit_slot_i,
  input  logic                                         lit_neg_i,
  input  logic [$clog2(NUM_SLOTS+1)-1:0]               list_slot_i,
  input  logic [$clog2(LIST_N+1)-1:0]                  list_len_i,
  output logic                                         valid_o,
  input  logic                                         ready_i,
  output logic [NUM_SLOTS*(BYTES_PER_SLOT*8+MORSELS_PER_SLOT*MORSEL_W)-1:0] buf_o,
  output logic [LIT_W-1:0]                             lit_o,
  output logic [LIST_N*MORSEL_W-1:0]                   list_o,
  output logic [LIST_N-1:0]                            list_mask_o
);

  localparam int LANE_W    = BYTES_PER_SLOT * 8 + MORSELS_PER_SLOT * MORSEL_W;
  localparam int BUF_W     = NUM_SLOTS * LANE_W;
  localparam int CON_BYTES = NUM_SLOTS * BYTES_PER_SLOT;
  localparam int CON_W     = CON_BYTES * 8;
  localparam int EXT_N     = NUM_SLOTS * MORSELS_PER_SLOT;
  localparam int EXT_W     = EXT_N * MORSEL_W;
  localparam int BOFF_W    = $clog2(CON_BYTES + 1);
  localparam int MOFF_W    = $clog2(EXT_N + 1);
  localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);
  localparam int LEN_W     = $clog2(LIST_N + 1);
  localparam int LIST_W    = LIST_N * MORSEL_W;

  logic adv;
  assign adv     = !valid_o || ready_i;
  assign ready_o = adv;

  // stage 1: count decode to offsets
  logic [NUM_SLOTS*BOFF_W-1:0] boff_d, boff_q;
  logic [NUM_SLOTS*MOFF_W-1:0] moff_d, moff_q;
  logic [NUM_SLOTS*3-1:0]      nb_d, nb_q;
  logic [NUM_SLOTS*2-1:0]      nm_d, nm_q;
  logic [CON_W-1:0]            con_q;
  logic [EXT_W-1:0]            ext_q;
  logic [SLOT_W-1:0]           lit_slot_q, list_slot_q;
  logic                        lit_neg_q;
  logic [LEN_W-1:0]            list_len_q;
  logic                        v1_q;

  fc_offset_calc #(
    .NUM_SLOTS(NUM_SLOTS), .BOFF_W(BOFF_W), .MOFF_W(MOFF_W)
  ) u_offs (
    .byte_code_i  (byte_code_i),
    .morsel_code_i(morsel_code_i),
    .boff_o       (boff_d),
    .moff_o       (moff_d),
    .nbytes_o     (nb_d),
    .nmors_o      (nm_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q        <= 1'b0;
      boff_q      <= '0;
      moff_q      <= '0;
      nb_q        <= '0;
      nm_q        <= '0;
      con_q       <= '0;
      ext_q       <= '0;
      lit_slot_q  <= '0;
      lit_neg_q   <= 1'b0;
      list_slot_q <= '0;
      list_len_q  <= '0;
    end else if (adv) begin
      v1_q        <= valid_i;
      boff_q      <= boff_d;
      moff_q      <= moff_d;
      nb_q        <= nb_d;
      nm_q        <= nm_d;
      con_q       <= con_blk_i;
      ext_q       <= ext_blk_i;
      lit_slot_q  <= lit_slot_i;
      lit_neg_q   <= lit_neg_i;
      list_slot_q <= list_slot_i;
      list_len_q  <= list_len_i;
    end
  end

  // stage 2: lane routing and field selection
  logic [BUF_W-1:0]  buf_d;
  logic [LIT_W-1:0]  lit_d;
  logic [LIST_W-1:0] list_d;
  logic [LIST_N-1:0] mask_d;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_lane
    fc_lane_router #(
      .BYTES_PER_SLOT(BYTES_PER_SLOT), .MORSELS_PER_SLOT(MORSELS_PER_SLOT),
      .MORSEL_W(MORSEL_W), .CON_W(CON_W), .EXT_W(EXT_W),
      .BOFF_W(BOFF_W), .MOFF_W(MOFF_W), .LANE_W(LANE_W)
    ) u_route (
      .con_i   (con_q),
      .ext_i   (ext_q),
      .boff_i  (boff_q[BOFF_W*s +: BOFF_W]),
      .moff_i  (moff_q[MOFF_W*s +: MOFF_W]),
      .nbytes_i(nb_q[3*s +: 3]),
      .nmors_i (nm_q[2*s +: 2]),
      .lane_o  (buf_d[LANE_W*s +: LANE_W])
    );
  end

  fc_field_select #(
    .BUF_W(BUF_W), .LANE_W(LANE_W), .SLOT_W(SLOT_W), .LIT_W(LIT_W),
    .LIST_N(LIST_N), .LIST_W(LIST_W), .LEN_W(LEN_W)
  ) u_sel (
    .buf_i      (buf_d),
    .lit_slot_i (lit_slot_q),
    .lit_neg_i  (lit_neg_q),
    .list_slot_i(list_slot_q),
    .list_len_i (list_len_q),
    .lit_o      (lit_d),
    .list_o     (list_d),
    .mask_o     (mask_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      buf_o       <= '0;
      lit_o       <= '0;
      list_o      <= '0;
      list_mask_o <= '0;
    end else if (adv) begin
      valid_o     <= v1_q;
      buf_o       <= buf_d;
      lit_o       <= lit_d;
      list_o      <= list_d;
      list_mask_o <= mask_d;
    end
  end

  // assertions
  a_r1_offsets_fit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q |-> (int'(boff_q[BOFF_W*(NUM_SLOTS-1) +: BOFF_W]) + int'(nb_q[3*(NUM_SLOTS-1) +: 3]) <= CON_BYTES));

  a_r5_mask_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((list_mask_o & (list_mask_o + 1'b1)) == '0));

  a_r6_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (valid_o == $past(v1_q)));

  a_r7_ready_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |-> !ready_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(buf_o) && $stable(lit_o)
                               && $stable(list_o) && $stable(list_mask_o)));

endmodule

// File: tb/fc_compositor_tb_top.sv
`timescale 1ns/1ps
module fc_compositor_tb_top;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         ready_o;
  logic [13:0]  byte_code_i = '0;
  logic [13:0]  morsel_code_i = '0;
  logic [223:0] con_blk_i = '0;
  logic [83:0]  ext_blk_i = '0;
  logic [2:0]   lit_slot_i = '0;
  logic         lit_neg_i = 1'b0;
  logic [2:0]   list_slot_i = '0;
  logic [4:0]   list_len_i = '0;
  logic         valid_o;
  logic         ready_i = 1'b1;
  logic [307:0] buf_o;
  logic [127:0] lit_o;
  logic [63:0]  list_o;
  logic [15:0]  list_mask_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  fc_compositor dut_i (.*);

  // {byte codes, morsel codes, lit slot, neg, list slot, list len}
  localparam int NV = 6;
  localparam logic [39:0] TAB [NV] = '{
    {14'h3FFF, 14'h3FFF, 3'd0, 1'b0, 3'd0, 5'd16},
    {14'h0000, 14'h0000, 3'd2, 1'b1, 3'd1, 5'd0},
    {14'h1B1E, 14'h2D87, 3'd5, 1'b0, 3'd6, 5'd11},
    {14'h1B1B, 14'h0E4E, 3'd4, 1'b1, 3'd5, 5'd20},
    {14'h2222, 14'h3030, 3'd6, 1'b0, 3'd3, 5'd1},
    {14'h0C03, 14'h1111, 3'd7, 1'b1, 3'd2, 5'd7}
  };

  function automatic logic [223:0] gen_con(input int seed);
    logic [223:0] c;
    for (int k = 0; k < 28; k++) c[8*k +: 8] = 8'(seed * 29 + k * 37 + 5);
    return c;
  endfunction

  function automatic logic [83:0] gen_ext(input int seed);
    logic [83:0] e;
    for (int k = 0; k < 21; k++) e[4*k +: 4] = 4'(seed * 7 + k * 5 + 3);
    return e;
  endfunction

  function automatic logic [307:0] m_buf(input logic [13:0] bc, input logic [13:0] mc,
                                         input logic [223:0] con, input logic [83:0] ext);
    logic [307:0] b;
    int bp, mp, nb, nm;
    b = '0; bp = 0; mp = 0;
    for (int s = 0; s < 7; s++) begin
      nb = (bc[2*s +: 2] == 2'd3) ? 4 : int'(bc[2*s +: 2]);
      nm = int'(mc[2*s +: 2]);
      for (int j = 0; j < nb; j++) b[44*s + 8*j +: 8] = con[8*(bp+j) +: 8];
      for (int j = 0; j < nm; j++) b[44*s + 32 + 4*j +: 4] = ext[4*(mp+j) +: 4];
      bp += nb; mp += nm;
    end
    return b;
  endfunction

  task automatic check(input bit ok, input string what, input logic [307:0] act, input logic [307:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic drive(input int idx);
    logic [39:0] t;
    t = TAB[idx];
    byte_code_i   = t[39:26];
    morsel_code_i = t[25:12];
    lit_slot_i    = t[11:9];
    lit_neg_i     = t[8];
    list_slot_i   = t[7:5];
    list_len_i    = t[4:0];
    con_blk_i     = gen_con(idx + 1);
    ext_blk_i     = gen_ext(idx + 1);
    valid_i       = 1'b1;
  endtask

  task automatic check_out(input int idx);
    logic [39:0]  t;
    logic [307:0] eb;
    logic [435:0] pad;
    logic [127:0] el;
    logic [63:0]  eli;
    logic [15:0]  em;
    t   = TAB[idx];
    eb  = m_buf(t[39:26], t[25:12], gen_con(idx + 1), gen_ext(idx + 1));
    pad = {128'b0, eb};
    el  = pad[44*int'(t[11:9]) +: 128];
    if (t[8]) el = ~el;
    eli = pad[44*int'(t[7:5]) +: 64];
    for (int k = 0; k < 16; k++) em[k] = (k < int'(t[4:0]));
    check(valid_o === 1'b1, $sformatf("R6 valid vec%0d", idx), 308'(valid_o), 308'(1));
    check(buf_o === eb, $sformatf("R1 R2 R3 buffer vec%0d", idx), buf_o, eb);
    check(lit_o === el, $sformatf("R4 literal vec%0d", idx), 308'(lit_o), 308'(el));
    check(list_o === eli && list_mask_o === em, $sformatf("R5 list vec%0d", idx),
          308'({list_mask_o, list_o}), 308'({em, eli}));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk_i);
    check(valid_o === 1'b0, "R8 valid in reset", 308'(valid_o), 308'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o === 1'b0 && ready_o === 1'b1, "R8 after reset",
          308'({valid_o, ready_o}), 308'(2'b01));

    // table walk, one instruction at a time
    for (int i = 0; i < NV; i++) begin
      drive(i);
      @(negedge clk_i);
      valid_i = 1'b0;
      @(negedge clk_i);
      check_out(i);
    end

    // R9 back-to-back issue
    @(negedge clk_i);
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        check(valid_o === 1'b1, $sformatf("R9 stream slot %0d", i), 308'(valid_o), 308'(1));
        check_out(i - 2);
      end
      if (i < NV) drive(i); else valid_i = 1'b0;
      @(negedge clk_i);
    end
    check(valid_o === 1'b0, "R9 stream drained", 308'(valid_o), 308'(0));

    // R7 stall with a second instruction waiting
    ready_i = 1'b0;
    drive(2);
    @(negedge clk_i);
    drive(3);
    @(negedge clk_i);
    valid_i = 1'b0;
    check(ready_o === 1'b0, "R7 ready low under stall", 308'(ready_o), 308'(0));
    repeat (3) @(negedge clk_i);
    check(ready_o === 1'b0, "R7 ready still low", 308'(ready_o), 308'(0));
    check_out(2);
    ready_i = 1'b1;
    @(negedge clk_i);
    check_out(3);
    @(negedge clk_i);
    check(valid_o === 1'b0, "R7 drained after stall", 308'(valid_o), 308'(0));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule